// File: doc/BRIEF.md
# Carry-Lookahead Integer ALU

A purely combinational integer arithmetic and logic unit. Two operands enter on the same cycle. A 2-bit opcode chooses one of four functions: bitwise AND, OR, XOR, or a two's-complement adder. When the adder is selected, a subtract control inverts the second operand and forces the carry-in to one.

The datapath is cut into fixed-width slices. Each bit makes a generate term (a AND b) and a propagate term (a XOR b). Inside a slice, every internal carry comes from a fully expanded sum-of-products of those terms. Each slice also reports a group generate and a group propagate. A second lookahead level, built the same way, turns these group terms into the carry-in of every slice. No carry ripples through the slices.

Beside the result, the unit reports a carry-out, a signed-overflow flag and a zero flag.

Top module: `cla_alu`

## Requirements
- R1: With op_i = 2'b00, result_o equals the bitwise AND of a_i and b_i.
- R2: With op_i = 2'b01, result_o equals the bitwise OR of a_i and b_i.
- R3: With op_i = 2'b11, result_o equals the bitwise XOR of a_i and b_i.
- R4: With op_i = 2'b10 and sub_i = 0, result_o equals (a_i + b_i) modulo 2^WIDTH, and carry_o equals bit WIDTH of the unsigned sum.
- R5: With op_i = 2'b10 and sub_i = 1, result_o equals (a_i - b_i) modulo 2^WIDTH, and carry_o is 1 exactly when a_i >= b_i as unsigned numbers.
- R6: For addition, ovf_o is 1 exactly when the top bits of a_i and b_i are equal and the top bit of result_o differs from them.
- R7: For subtraction, ovf_o is 1 exactly when the top bits of a_i and b_i differ and the top bit of result_o differs from the top bit of a_i.
- R8: For op_i values 2'b00, 2'b01 and 2'b11, ovf_o and carry_o are 0, and sub_i has no effect on any output.
- R9: zero_o is 1 exactly when every bit of result_o is 0, for every opcode.
- R10: A carry produced in the lowest bit reaches carry_o through every slice when all higher bits propagate. For example, 0xFFFFFFFF + 1 gives result 0, carry_o = 1 and zero_o = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| op_i | input | 2 | Function select: 00 AND, 01 OR, 10 add/subtract, 11 XOR |
| sub_i | input | 1 | Subtract when the adder is selected |
| result_o | output | WIDTH | Selected result |
| carry_o | output | 1 | Carry out of the top bit (adder only) |
| ovf_o | output | 1 | Signed overflow (adder only) |
| zero_o | output | 1 | Result is all zeros |

## Verification
The bench builds the unit with its defaults, WIDTH = 32 and SLICE_W = 4. That gives eight slices, so the upper lookahead level resolves a chain eight groups long. With these values a single carry can be driven across every group boundary, from bit 0 to carry_o. Directed vectors cover the overflow boundaries at the most negative and most positive values. They also cover equal-operand subtraction and carry chains that stop at slice edges. A long pseudo-random run then exercises every opcode with both settings of sub_i.

// File: rtl/cla_alu_pkg.sv
package cla_alu_pkg;
  typedef enum logic [1:0] {
    OP_AND = 2'b00,
    OP_OR  = 2'b01,
    OP_ADD = 2'b10,
    OP_XOR = 2'b11
  } alu_op_e;

  localparam int unsigned LA_MAX = 64;

  // Sum-of-products carry into position upto+1: OR over every generate term and cin,
  // each ANDed with all propagate terms above it.
  function automatic logic lookahead_carry(input logic [LA_MAX-1:0] g,
                                           input logic [LA_MAX-1:0] p,
                                           input logic cin,
                                           input int unsigned upto);
    logic acc;
    logic term;
    acc = 1'b0;
    for (int j = -1; j <= int'(upto); j++) begin
      term = (j < 0) ? cin : g[j];
      for (int k = j + 1; k <= int'(upto); k++) term = term & p[k];
      acc = acc | term;
    end
    return acc;
  endfunction
endpackage

// File: rtl/cla_bit_cell.sv
module cla_bit_cell
  import cla_alu_pkg::*;
(
  input  logic    a_i,
  input  logic    b_i,
  input  logic    c_i,
  input  alu_op_e op_i,
  output logic    g_o,
  output logic    p_o,
  output logic    res_o
);
  assign g_o = a_i & b_i;
  assign p_o = a_i ^ b_i;

  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_ADD:  res_o = p_o ^ c_i;
      default: res_o = a_i ^ b_i;
    endcase
  end
endmodule

// File: rtl/cla_slice.sv
module cla_slice
  import cla_alu_pkg::*;
#(
  parameter int unsigned SLICE_W = 4
) (
  input  logic [SLICE_W-1:0] a_i,
  input  logic [SLICE_W-1:0] b_i,
  input  logic               c_i,
  input  alu_op_e            op_i,
  output logic [SLICE_W-1:0] res_o,
  output logic               gg_o,
  output logic               gp_o
);
  logic [SLICE_W-1:0] g, p;
  logic [SLICE_W-1:0] c;

  for (genvar i = 0; i < SLICE_W; i++) begin : g_bit
    if (i == 0) begin : g_c0
      assign c[i] = c_i;
    end else begin : g_cn
      assign c[i] = lookahead_carry(LA_MAX'(g), LA_MAX'(p), c_i, i - 1);
    end
    cla_bit_cell u_cell (
      .a_i  (a_i[i]),
      .b_i  (b_i[i]),
      .c_i  (c[i]),
      .op_i (op_i),
      .g_o  (g[i]),
      .p_o  (p[i]),
      .res_o(res_o[i])
    );
  end

  assign gg_o = lookahead_carry(LA_MAX'(g), LA_MAX'(p), 1'b0, SLICE_W - 1);
  assign gp_o = &p;
endmodule

// File: rtl/cla_group_unit.sv
module cla_group_unit
  import cla_alu_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 8
) (
  input  logic [NUM_GROUPS-1:0] gg_i,
  input  logic [NUM_GROUPS-1:0] gp_i,
  input  logic                  c0_i,
  output logic [NUM_GROUPS:0]   c_o
);
  assign c_o[0] = c0_i;
  for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_grp
    assign c_o[k+1] = lookahead_carry(LA_MAX'(gg_i), LA_MAX'(gp_i), c0_i, k);
  end
endmodule

// File: rtl/cla_alu.sv
module cla_alu
  import cla_alu_pkg::*;
#(
  parameter int unsigned WIDTH   = 32,
  parameter int unsigned SLICE_W = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       op_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             ovf_o,
  output logic             zero_o
);
  localparam int unsigned NUM_SLICES = WIDTH / SLICE_W;
  localparam int unsigned MSB        = WIDTH - 1;

  alu_op_e              op;
  logic                 is_add, inv_b;
  logic [WIDTH-1:0]     b_eff;
  logic [NUM_SLICES-1:0] gg, gp;
  logic [NUM_SLICES:0]   c;

  assign op     = alu_op_e'(op_i);
  assign is_add = (op == OP_ADD);
  assign inv_b  = is_add & sub_i;
  assign b_eff  = b_i ^ {WIDTH{inv_b}};

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    cla_slice #(.SLICE_W(SLICE_W)) u_slice (
      .a_i  (a_i[s*SLICE_W +: SLICE_W]),
      .b_i  (b_eff[s*SLICE_W +: SLICE_W]),
      .c_i  (c[s]),
      .op_i (op),
      .res_o(result_o[s*SLICE_W +: SLICE_W]),
      .gg_o (gg[s]),
      .gp_o (gp[s])
    );
  end

  cla_group_unit #(.NUM_GROUPS(NUM_SLICES)) u_groups (
    .gg_i(gg),
    .gp_i(gp),
    .c0_i(inv_b),
    .c_o (c)
  );

  assign carry_o = is_add & c[NUM_SLICES];
  assign ovf_o   = is_add & (a_i[MSB] == b_eff[MSB]) & (result_o[MSB] != a_i[MSB]);
  assign zero_o  = ~|result_o;
endmodule

// File: rtl/cla_alu_chk.sv
module cla_alu_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [1:0]       op_i,
  input logic             sub_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o,
  input logic             ovf_o,
  input logic             zero_o
);
  localparam int unsigned M = WIDTH - 1;
  logic [WIDTH:0] ref_sum;
  logic           zero_unused;

  assign ref_sum     = {1'b0, a_i} + {1'b0, b_i};
  assign zero_unused = zero_o;

  always_comb begin
    if (op_i == 2'b00) AST_AND_RESULT: assert (result_o == (a_i & b_i)); // R1
    if (op_i == 2'b01) AST_OR_RESULT: assert (result_o == (a_i | b_i)); // R2
    if (op_i == 2'b11) AST_XOR_RESULT: assert (result_o == (a_i ^ b_i)); // R3
    if (op_i == 2'b10 && !sub_i) AST_ADD_SUM: assert ({carry_o, result_o} == ref_sum); // R4
    if (op_i == 2'b10 && sub_i)
      AST_SUB_DIFF: assert (result_o == a_i - b_i && carry_o == (a_i >= b_i)); // R5
    if (op_i == 2'b10 && !sub_i)
      AST_ADD_OVF: assert (ovf_o == ((a_i[M] == b_i[M]) && (result_o[M] != a_i[M]))); // R6
    if (op_i == 2'b10 && sub_i)
      AST_SUB_OVF: assert (ovf_o == ((a_i[M] != b_i[M]) && (result_o[M] != a_i[M]))); // R7
    if (op_i != 2'b10) AST_LOGIC_FLAGS: assert (!ovf_o && !carry_o); // R8
  end
endmodule

bind cla_alu cla_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .op_i    (op_i),
  .sub_i   (sub_i),
  .result_o(result_o),
  .carry_o (carry_o),
  .ovf_o   (ovf_o),
  .zero_o  (zero_o)
);

// File: tb/cla_alu_tb_top.sv
module cla_alu_tb_top;
  localparam int unsigned W        = 32;
  localparam int unsigned CLK_PER  = 10;
  localparam int unsigned WD_LIMIT = 150000;

  typedef struct {
    logic [W-1:0] a, b;
    logic [1:0]   op;
    logic         sub;
    logic [W-1:0] res;
    logic         cy, ov, zf;
    string        tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [W-1:0] a, b;
  logic [1:0]   op;
  logic         sub;
  logic [W-1:0] res;
  logic         cy, ov, zf;
  item_t        sb_q[$];
  int           checks = 0, fails = 0;
  bit           done = 1'b0;
  logic [31:0]  rng = 32'h1234_5678;

  always #(CLK_PER/2) clk = ~clk;

  cla_alu #(.WIDTH(W), .SLICE_W(4)) dut_i (
    .a_i(a), .b_i(b), .op_i(op), .sub_i(sub),
    .result_o(res), .carry_o(cy), .ovf_o(ov), .zero_o(zf)
  );

  function automatic item_t model(logic [W-1:0] x, logic [W-1:0] y, logic [1:0] o, logic s);
    item_t it;
    logic [W:0] sum;
    it.a = x; it.b = y; it.op = o; it.sub = s; it.cy = 1'b0; it.ov = 1'b0;
    case (o)
      2'b00: begin it.res = x & y; it.tag = "R1"; end
      2'b01: begin it.res = x | y; it.tag = "R2"; end
      2'b11: begin it.res = x ^ y; it.tag = "R3"; end
      default: begin
        if (s) begin
          it.res = x - y;
          it.cy  = (x >= y);
          it.ov  = (x[W-1] != y[W-1]) && (it.res[W-1] != x[W-1]);
          it.tag = "R5/R7";
        end else begin
          sum    = {1'b0, x} + {1'b0, y};
          it.res = sum[W-1:0];
          it.cy  = sum[W];
          it.ov  = (x[W-1] == y[W-1]) && (it.res[W-1] != x[W-1]);
          it.tag = "R4/R6";
        end
      end
    endcase
    if (o != 2'b10) it.tag = {it.tag, "/R8"};
    it.zf = (it.res == '0);
    return it;
  endfunction

  task automatic drive(logic [W-1:0] x, logic [W-1:0] y, logic [1:0] o, logic s, string extra);
    item_t it;
    @(negedge clk);
    a = x; b = y; op = o; sub = s;
    it = model(x, y, o, s);
    if (extra != "") it.tag = {extra, "/", it.tag};
    sb_q.push_back(it);
  endtask

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: one queued item per rising edge, inputs were set at the preceding falling edge
  always @(posedge clk) begin
    if (rst_ni && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(it.tag, res, it.res, "result");
      check(it.tag, W'(cy), W'(it.cy), "carry");
      check(it.tag, W'(ov), W'(it.ov), "ovf");
      check("R9", W'(zf), W'(it.zf), "zero");
    end
  end

  function automatic logic [31:0] next_rng(logic [31:0] v);
    logic [31:0] t;
    t = v ^ (v << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  initial begin
    a = '0; b = '0; op = 2'b00; sub = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset / idle state: all zero inputs, AND -> zero result
    drive('0, '0, 2'b00, 1'b0, "R9");
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 2'b00, 1'b0, "R1");
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 2'b01, 1'b0, "R2");
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 2'b11, 1'b0, "R3");
    drive(32'hAAAA_5555, 32'h5555_AAAA, 2'b00, 1'b1, "R8"); // sub ignored, zero result
    drive(32'hDEAD_BEEF, 32'hDEAD_BEEF, 2'b11, 1'b1, "R8");
    drive(32'hFFFF_FFFF, 32'h0000_0001, 2'b10, 1'b0, "R10");
    drive(32'h0000_000F, 32'h0000_0001, 2'b10, 1'b0, "R10");
    drive(32'h0FFF_FFFF, 32'h0000_0001, 2'b10, 1'b0, "R10");
    drive(32'h7FFF_FFFF, 32'h0000_0001, 2'b10, 1'b0, "R6");
    drive(32'h8000_0000, 32'h8000_0000, 2'b10, 1'b0, "R6");
    drive(32'h8000_0000, 32'h0000_0001, 2'b10, 1'b1, "R7");
    drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 2'b10, 1'b1, "R7");
    drive(32'h1234_5678, 32'h1234_5678, 2'b10, 1'b1, "R5");
    drive(32'h0000_0000, 32'h0000_0001, 2'b10, 1'b1, "R5");
    drive(32'h0000_0005, 32'h0000_0003, 2'b10, 1'b1, "R5");
    for (int n = 0; n < 2000; n++) begin
      logic [W-1:0] x, y;
      rng = next_rng(rng); x = rng;
      rng = next_rng(rng); y = (n % 7 == 0) ? ~x : rng;
      rng = next_rng(rng);
      drive(x, y, rng[1:0], rng[7], "");
    end
    @(posedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule